// File: doc/BRIEF.md
# Serial-Configured Clock Fanout Enable Controller

This block takes one input clock and drives ten gated copies of it. Each copy can be switched on or off through a write-only two-wire serial slave. A faster system clock oversamples the serial clock and data lines. The slave detects bus framing, matches a fixed device byte and then walks a fixed-order byte sequence with no subaddress. The first two bytes after the device byte are acknowledged and thrown away. The next three bytes carry the enable flags for the ten outputs, scattered across the three bytes. Any byte after those three is acknowledged and dropped.

The enables cross into the input-clock domain and change only while that clock is low, so a copy never shows a shortened pulse. A separate active-low pad-enable input releases all ten pads at once, whatever the register contents.

Each output pair is meant to drive a pad. `fan_o` is the value and `fan_oe` is the drive enable; a low `fan_oe` means the pad is high impedance. The acknowledge works the same way: a high `sda_oe` means the data line is pulled low.

Top module: `clkfan_cfg`

## Requirements
- R1: After reset all ten enables are set, each `fan_o` bit equals `ref_clk`, and `sda_oe` is low.
- R2: Only the device byte 0xD2 (address 1101001 followed by write bit 0) is acknowledged. Any other address, and a read request (0xD3), gets no acknowledge. Every byte after that is ignored until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts the sequence at the device byte.
- R4: The two bytes that follow the device byte are acknowledged and have no effect on any output.
- R5: The third, fourth and fifth bytes after the device byte set the enables, with 1 meaning enabled. In the third byte, bits 3..0 drive outputs 3..0. In the fourth byte, bit 7 drives output 9 and bit 6 drives output 8. In the fifth byte, bits 7..4 drive outputs 7..4. All other bits are ignored.
- R6: A sequence cut short by STOP updates only the bytes it delivered. Bytes beyond the fifth are acknowledged and change nothing.
- R7: A STOP in the middle of a byte leaves every enable unchanged.
- R8: A disabled output stays low. An enabled output equals `ref_clk`. An output is never high while `ref_clk` is low.
- R9: While `hiz_n` is low, every `fan_oe` bit is low, with no clock involved. While it is high, every `fan_oe` bit is high.
- R10: `sda_oe` rises on the third `clk` edge after SCL falls for the eighth bit of an acknowledged byte. It falls on the third edge after the ninth SCL fall, and it is never high while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Clock to be fanned out |
| hiz_n | input | 1 | Low releases all output pads |
| fan_o | output | 10 | Gated copies of `ref_clk` |
| fan_oe | output | 10 | Per-output pad drive enable |

## Verification
The serial lines pass through two synchronizer stages and one edge-detect stage. The acknowledge therefore appears on the third `clk` edge after an SCL fall, and the bench checks `sda_oe` both two and three edges after each such fall. An enable register changes during the acknowledge, but the output only follows after two falling edges of `ref_clk`. The bench waits several `ref_clk` periods before it compares `fan_o` against its own expected vector, sampling a few nanoseconds into the high and low phases. `fan_oe` and the no-runt condition depend on no latency, so they are compared on every `clk` cycle.

// File: rtl/clkfan_cfg.sv
`timescale 1ns/100ps
module clkfan_cfg #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int unsigned NOUT    = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            ref_clk,
  input  logic            hiz_n,
  output logic [NOUT-1:0] fan_o,
  output logic [NOUT-1:0] fan_oe
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [2:0] LAST_POS  = 3'd6;

  logic       scl_m, scl_q, scl_d, sda_m, sda_q, sda_d;
  logic       active, ack_drv;
  logic [3:0] bitcnt;
  logic [2:0] bytepos;
  logic [7:0] shreg;
  logic [NOUT-1:0] en_reg, en_meta, en_ref;

  wire start_ev = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_d, scl_q, scl_m} <= 3'b111;
      {sda_d, sda_q, sda_m} <= 3'b111;
      active  <= 1'b0;
      ack_drv <= 1'b0;
      bitcnt  <= '0;
      bytepos <= '0;
      shreg   <= '0;
      en_reg  <= '1;
    end else begin
      {scl_d, scl_q, scl_m} <= {scl_q, scl_m, scl_i};
      {sda_d, sda_q, sda_m} <= {sda_q, sda_m, sda_i};
      if (start_ev) begin
        active  <= 1'b1;
        ack_drv <= 1'b0;
        bitcnt  <= '0;
        bytepos <= '0;
      end else if (stop_ev) begin
        active  <= 1'b0;
        ack_drv <= 1'b0;
      end else if (active) begin
        if (scl_rise && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_q};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (ack_drv) begin
            ack_drv <= 1'b0;
            bitcnt  <= '0;
            if (bytepos != LAST_POS) bytepos <= bytepos + 3'd1;
          end else if (bitcnt == 4'd8) begin
            if (bytepos == 3'd0 && shreg != ADDR_BYTE) begin
              active <= 1'b0;
            end else begin
              ack_drv <= 1'b1;
              case (bytepos)
                3'd3:    en_reg[3:0] <= shreg[3:0];
                3'd4:    en_reg[9:8] <= shreg[7:6];
                3'd5:    en_reg[7:4] <= shreg[7:4];
                default: ;
              endcase
            end
          end
        end
      end
    end
  end

  assign sda_oe = ack_drv;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_meta <= '1;
      en_ref  <= '1;
    end else begin
      en_meta <= en_reg;
      en_ref  <= en_meta;
    end
  end

  assign fan_o  = {NOUT{ref_clk}} & en_ref;
  assign fan_oe = {NOUT{hiz_n}};
endmodule

module clkfan_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_clk,
  input logic       scl_q,
  input logic       scl_d,
  input logic       active,
  input logic       sda_oe,
  input logic [9:0] en_reg,
  input logic [9:0] fan_o
);
  // R10
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_d) && !$past(scl_q)));
  // R10
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_oe);
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(scl_d) && !$past(scl_q)) |-> $stable(en_reg));
  // R8
  no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_o & ~{10{ref_clk}}) == 10'd0);
endmodule

bind clkfan_cfg clkfan_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .scl_q(scl_q), .scl_d(scl_d),
  .active(active), .sda_oe(sda_oe), .en_reg(en_reg), .fan_o(fan_o)
);

// File: tb/clkfan_cfg_test.sv
`timescale 1ns/100ps
module clkfan_cfg_test;
  logic clk = 0, rst_n = 0, ref_clk = 0, hiz_n = 1, m_scl = 1, m_sda = 1;
  logic sda_oe;
  logic [9:0] fan_o, fan_oe;
  logic [9:0] exp_en = '1;
  int nchk = 0, nfail = 0;
  wire sda_bus = m_sda & ~sda_oe;

  clkfan_cfg uut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .ref_clk(ref_clk), .hiz_n(hiz_n), .fan_o(fan_o), .fan_oe(fan_oe));

  always #4 clk = ~clk;
  initial begin #0.3; forever #13.5 ref_clk = ~ref_clk; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(fan_oe == {10{hiz_n}}, "R9", fan_oe, {10{hiz_n}});
    chk((fan_o & ~{10{ref_clk}}) == 0, "R8", fan_o, 0);
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; ticks(5); m_scl = 1; ticks(10); m_sda = 0; ticks(10); m_scl = 0; ticks(5);
  endtask

  task automatic bus_stop();
    m_sda = 0; ticks(5); m_scl = 1; ticks(10); m_sda = 1; ticks(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; ticks(5); m_scl = 1; ticks(10); m_scl = 0; ticks(5);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; ticks(5); m_scl = 1; ticks(10); m_scl = 0;
      if (i > 0) ticks(5);
    end
    ticks(2); chk(sda_oe == 0, "R10 early", sda_oe, 0);
    ticks(1); chk(sda_oe == ack, "R10 rise", sda_oe, ack);
    m_sda = 1; ticks(2); m_scl = 1; ticks(5);
    chk(sda_bus == !ack, req, sda_bus, !ack);
    ticks(5); m_scl = 0;
    ticks(2); chk(sda_oe == ack, "R10 hold", sda_oe, ack);
    ticks(1); chk(sda_oe == 0, "R10 release", sda_oe, 0);
    ticks(2);
  endtask

  task automatic check_outputs(input string req);
    repeat (4) @(posedge ref_clk);
    #3 chk(fan_o == exp_en, req, fan_o, exp_en);
    @(negedge ref_clk);
    #3 chk(fan_o == 0, "R8 low phase", fan_o, 0);
  endtask

  task automatic write_cfg(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2);
    bus_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'h5A, 1, "R4 command ack");
    send_byte(8'h03, 1, "R4 count ack");
    send_byte(r0, 1, "R5 reg0 ack");
    send_byte(r1, 1, "R5 reg1 ack");
    send_byte(r2, 1, "R5 reg2 ack");
    bus_stop();
  endtask

  initial begin
    ticks(5); rst_n = 1; ticks(5);
    chk(sda_oe == 0, "R1 ack idle", sda_oe, 0);
    check_outputs("R1 reset enables");

    write_cfg(8'hF5, 8'h7F, 8'hAF);
    exp_en = 10'h1A5;
    check_outputs("R5 scattered map");

    bus_start();
    send_byte(8'hD0, 0, "R2 wrong address");
    send_byte(8'h00, 0, "R2 ignored");
    send_byte(8'h00, 0, "R2 ignored");
    send_byte(8'h00, 0, "R2 ignored");
    bus_stop();
    check_outputs("R2 wrong address no effect");

    bus_start();
    send_byte(8'hD3, 0, "R2 read refused");
    send_byte(8'h00, 0, "R2 ignored");
    send_byte(8'h00, 0, "R2 ignored");
    send_byte(8'h00, 0, "R2 ignored");
    bus_stop();
    check_outputs("R2 read no effect");

    bus_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'hFF, 1, "R4 command ack");
    send_byte(8'hFF, 1, "R4 count ack");
    send_byte(8'h0A, 1, "R6 reg0 only");
    bus_stop();
    exp_en = 10'h1AA;
    check_outputs("R6 partial write");

    bus_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'h00, 1, "R4 command ack");
    send_byte(8'h00, 1, "R4 count ack");
    send_bits(8'h00, 4);
    bus_stop();
    check_outputs("R7 stop mid-byte");

    bus_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'h11, 1, "R4 command ack");
    bus_start();
    send_byte(8'hD2, 1, "R3 restart address");
    send_byte(8'hD2, 1, "R3 command ack");
    send_byte(8'h00, 1, "R3 count ack");
    send_byte(8'h03, 1, "R3 reg0 ack");
    bus_stop();
    exp_en = 10'h1A3;
    check_outputs("R3 repeated start");

    bus_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'h00, 1, "R4 command ack");
    send_byte(8'h00, 1, "R4 count ack");
    send_byte(8'h0F, 1, "R5 reg0");
    send_byte(8'hC0, 1, "R5 reg1");
    send_byte(8'hF0, 1, "R5 reg2");
    send_byte(8'h00, 1, "R6 extra ack");
    send_byte(8'h00, 1, "R6 extra ack");
    bus_stop();
    exp_en = 10'h3FF;
    check_outputs("R6 extra bytes discarded");

    write_cfg(8'h00, 8'h00, 8'h00);
    exp_en = 10'h000;
    check_outputs("R8 all disabled low");

    @(negedge clk); #1 hiz_n = 0;
    #1 chk(fan_oe == 0, "R9 async release", fan_oe, 0);
    write_cfg(8'h00, 8'h80, 8'h00);
    exp_en = 10'h200;
    check_outputs("R9 registers still load");
    @(negedge clk); #1 hiz_n = 1;
    #1 chk(fan_oe == 10'h3FF, "R9 drive restored", fan_oe, 10'h3FF);
    ticks(4);
    finish_up();
  end

  initial begin
    #(200000 * 8);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule